// File: doc/BRIEF.md
# Two-Master Bus Arbiter with CPU Release Points

This block decides which of two masters may drive a shared external bus: the on-chip CPU or one external bus master. The external master always has the higher priority. The arbiter looks at the external request on every clock. It moves the bus away from the CPU only at a moment when the CPU can safely let go, so a request never cuts a CPU bus cycle short.

The CPU reports its state each clock through four status inputs:
- `cpuCycleEnd` marks the last clock of a bus cycle.
- `cpuSplitFirst` says that the cycle is the first byte of a word access split into two byte accesses.
- `cpuIntBusy` flags internal work that does not use the bus.
- `cpuSleep` flags sleep mode.

The external request is asynchronous and passes through a synchronizer. Once the external master holds the bus, it keeps it for as long as it requests. The bus then returns to the CPU after one clock in which neither master owns it. While the CPU does not own the bus, any bus cycle it wants to start is stalled.

Top module: `bus_share_arbiter`

## Requirements
- R1: `extAck` and `cpuGrant` are never high in the same clock.
- R2: While reset is active and directly after it, `cpuGrant` is 1 and `extAck` is 0.
- R3: `extReq` passes through two synchronizing flops. Take a request first sampled high at a rising edge, with the CPU at a release point throughout. `extAck` rises at the second rising edge after that one, and `cpuGrant` falls at the same edge.
- R4: While the CPU runs bus cycles, the bus is handed over only at a clock with `cpuCycleEnd`=1 and `cpuSplitFirst`=0. A clock in the middle of a bus cycle is never a release point.
- R5: Consider a cycle that ends with `cpuSplitFirst`=1. From that clock until the next clock with `cpuCycleEnd`=1, no handover happens, even if `cpuIntBusy` or `cpuSleep` is high.
- R6: Outside an open split word, a clock with `cpuIntBusy`=1 is a release point. A pending synchronized request is granted at the next edge.
- R7: Outside an open split word, a clock with `cpuSleep`=1 is a release point in the same way.
- R8: While `extAck` is 1 and the synchronized request is still high, `extAck` stays 1 at the next edge.
- R9: Once the synchronized request is low, `extAck` falls at the next edge, and `cpuGrant` rises at the edge after that.
- R10: `cpuStall` equals `cpuBusNeed` AND NOT `cpuGrant`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extReq | input | 1 | External master bus request (asynchronous) |
| cpuCycleEnd | input | 1 | Last clock of a CPU bus cycle |
| cpuSplitFirst | input | 1 | The current cycle is the first byte of a split word |
| cpuIntBusy | input | 1 | CPU is busy internally with no bus activity |
| cpuSleep | input | 1 | CPU is in sleep mode |
| cpuBusNeed | input | 1 | CPU wants to run a bus cycle |
| extAck | output | 1 | External master owns the bus |
| cpuGrant | output | 1 | CPU owns the bus |
| cpuStall | output | 1 | CPU must hold back its bus cycle |

## Verification
The hardest case to reach is a synchronized request that becomes valid inside an open split word, while the CPU status would otherwise count as a release point. To get there, the stimulus raises the request at the start of a short first-byte cycle, follows it with a long second-byte cycle, and drives internal-busy and sleep during that second byte. The earliest allowed handover is then the clock where the second byte ends. A stretch of random status and request patterns then runs against the cycle-level reference model to reach the rarer orderings.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_CPU  = 2'd0,
    ST_EXT  = 2'd1,
    ST_BACK = 2'd2
  } arbState_t;

  typedef struct packed {
    logic grantExt;
    logic dropExt;
    logic grantCpu;
  } arbStrobe_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extReq,
  input  logic       cpuCycleEnd,
  input  logic       cpuSplitFirst,
  input  logic       cpuIntBusy,
  input  logic       cpuSleep,
  input  logic       cpuBusNeed,
  input  arbStrobe_t strobe,
  output logic       reqSync,
  output logic       releaseNow,
  output logic       extAck,
  output logic       cpuGrant,
  output logic       cpuStall
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   splitOpen;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[0] <= 1'b0;
        else       syncChain[0] <= extReq;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else       syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign reqSync = syncChain[LAST];

  // A split word stays open from its first-byte end to the next cycle end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            splitOpen <= 1'b0;
    else if (cpuCycleEnd) splitOpen <= cpuSplitFirst;
  end

  always_comb begin
    if (cpuCycleEnd) releaseNow = !cpuSplitFirst;
    else             releaseNow = !splitOpen && (cpuIntBusy || cpuSleep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extAck   <= 1'b0;
      cpuGrant <= 1'b1;
    end else begin
      if (strobe.grantExt) begin
        extAck   <= 1'b1;
        cpuGrant <= 1'b0;
      end
      if (strobe.dropExt)  extAck   <= 1'b0;
      if (strobe.grantCpu) cpuGrant <= 1'b1;
    end
  end

  assign cpuStall = cpuBusNeed && !cpuGrant;

  assert_grant_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(extAck && cpuGrant));

  assert_split_no_handover_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((splitOpen && !cpuCycleEnd) || (cpuCycleEnd && cpuSplitFirst)) |=> !$rose(extAck));

  assert_handover_at_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extAck) |-> $past(releaseNow && reqSync));

  assert_ack_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (extAck && reqSync) |=> extAck);

  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (extAck && !reqSync) |=> !extAck);

  assert_cpu_return_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extAck) |=> cpuGrant);

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  input  logic       releaseNow,
  output arbStrobe_t strobe
);

  arbState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CPU;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_CPU: if (reqSync && releaseNow) begin
        strobe.grantExt = 1'b1;
        stateNext       = ST_EXT;
      end
      ST_EXT: if (!reqSync) begin
        strobe.dropExt = 1'b1;
        stateNext      = ST_BACK;
      end
      ST_BACK: begin
        strobe.grantCpu = 1'b1;
        stateNext       = ST_CPU;
      end
      default: stateNext = ST_CPU;
    endcase
  end

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  assert_back_is_brief_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BACK) |=> (state == ST_CPU));

endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extReq,
  input  logic cpuCycleEnd,
  input  logic cpuSplitFirst,
  input  logic cpuIntBusy,
  input  logic cpuSleep,
  input  logic cpuBusNeed,
  output logic extAck,
  output logic cpuGrant,
  output logic cpuStall
);

  arbStrobe_t strobe;
  logic       reqSync;
  logic       releaseNow;

  arb_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .extReq       (extReq),
    .cpuCycleEnd  (cpuCycleEnd),
    .cpuSplitFirst(cpuSplitFirst),
    .cpuIntBusy   (cpuIntBusy),
    .cpuSleep     (cpuSleep),
    .cpuBusNeed   (cpuBusNeed),
    .strobe       (strobe),
    .reqSync      (reqSync),
    .releaseNow   (releaseNow),
    .extAck       (extAck),
    .cpuGrant     (cpuGrant),
    .cpuStall     (cpuStall)
  );

  arb_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqSync   (reqSync),
    .releaseNow(releaseNow),
    .strobe    (strobe)
  );

endmodule

// File: tb/bus_share_arbiter_tb.sv
`timescale 1ns/1ps
module bus_share_arbiter_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extReq = 1'b0, cpuCycleEnd = 1'b0, cpuSplitFirst = 1'b0;
  logic cpuIntBusy = 1'b0, cpuSleep = 1'b0, cpuBusNeed = 1'b0;
  logic extAck, cpuGrant, cpuStall;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;
  string phase = "R2";

  // reference model state: mode 0 = CPU owns, 1 = external owns, 2 = gap
  int mMode = 0;
  bit mExt = 1'b0, mCpu = 1'b1, mSplit = 1'b0;
  bit syncQ[$] = '{1'b0, 1'b0};

  always #4 clk = ~clk;

  bus_share_arbiter u_dut (
    .clk(clk), .rstN(rstN), .extReq(extReq), .cpuCycleEnd(cpuCycleEnd),
    .cpuSplitFirst(cpuSplitFirst), .cpuIntBusy(cpuIntBusy), .cpuSleep(cpuSleep),
    .cpuBusNeed(cpuBusNeed), .extAck(extAck), .cpuGrant(cpuGrant), .cpuStall(cpuStall)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mMode = 0; mExt = 1'b0; mCpu = 1'b1; mSplit = 1'b0;
      syncQ = '{1'b0, 1'b0};
    end else begin
      bit reqS, rel;
      reqS = syncQ[0];
      void'(syncQ.pop_front());
      syncQ.push_back(extReq);
      if (cpuCycleEnd) rel = !cpuSplitFirst;
      else             rel = !mSplit && (cpuIntBusy || cpuSleep);
      if (cpuCycleEnd) mSplit = cpuSplitFirst;
      case (mMode)
        0: if (reqS && rel) begin mMode = 1; mExt = 1'b1; mCpu = 1'b0; end
        1: if (!reqS) begin mMode = 2; mExt = 1'b0; end
        default: begin mMode = 0; mCpu = 1'b1; end
      endcase
    end
  end

  task automatic check(string tag, string name, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %b expected %b at cycle %0d", tag, name, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(phase, "extAck", extAck, mExt);
      check(phase, "cpuGrant", cpuGrant, mCpu);
      check("R10", "cpuStall", cpuStall, cpuBusNeed && !mCpu);
      check("R1", "exclusive", extAck && cpuGrant, 1'b0);
    end
  end

  task automatic drive(bit e, bit s, bit ib, bit sl, bit nd, bit rq);
    @(negedge clk); #1;
    cpuCycleEnd = e; cpuSplitFirst = s; cpuIntBusy = ib;
    cpuSleep = sl; cpuBusNeed = nd; extReq = rq;
  endtask

  task automatic busCycle(int len, bit split, bit rq);
    for (int i = 0; i < len; i++) drive(i == len - 1, split, 1'b0, 1'b0, 1'b1, rq);
  endtask

  task automatic quiet(int n, bit ib, bit sl, bit nd, bit rq);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, ib, sl, nd, rq);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2", "extAck in reset", extAck, 1'b0);
    check("R2", "cpuGrant in reset", cpuGrant, 1'b1);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R2", "extAck after reset", extAck, 1'b0);
    check("R2", "cpuGrant after reset", cpuGrant, 1'b1);

    phase = "R10"; for (int k = 0; k < 3; k++) busCycle(2, 1'b0, 1'b0);
    // mid-cycle clocks only: no handover
    phase = "R4"; quiet(6, 1'b0, 1'b0, 1'b1, 1'b1);
    busCycle(4, 1'b0, 1'b1); busCycle(4, 1'b0, 1'b1);
    phase = "R8"; quiet(10, 1'b0, 1'b0, 1'b1, 1'b1);
    phase = "R9"; quiet(6, 1'b0, 1'b0, 1'b1, 1'b0);
    // split word: short first byte, long second byte with release-like status
    phase = "R5"; drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    quiet(4, 1'b0, 1'b0, 1'b1, 1'b1);
    quiet(5, 1'b0, 1'b0, 1'b0, 1'b0);
    phase = "R6"; quiet(8, 1'b1, 1'b0, 1'b0, 1'b1); quiet(5, 1'b1, 1'b0, 1'b0, 1'b0);
    phase = "R7"; quiet(8, 1'b0, 1'b1, 1'b0, 1'b1); quiet(5, 1'b0, 1'b1, 1'b0, 1'b0);
    phase = "R3"; drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    quiet(8, 1'b0, 1'b1, 1'b0, 1'b0);

    phase = "R1";
    begin
      bit rq = 1'b0;
      for (int i = 0; i < 400; i++) begin
        bit e, s;
        if ($urandom_range(7) == 0) rq = ~rq;
        e = ($urandom_range(2) == 0);
        s = e && ($urandom_range(1) == 0);
        drive(e, s, $urandom_range(5) == 0, $urandom_range(7) == 0,
              $urandom_range(1) == 0, rq);
      end
    end
    quiet(6, 1'b0, 1'b0, 1'b0, 1'b0);
    finishRun();
  end

  initial begin
    wait (cycles > 5000);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    finishRun();
  end

endmodule